// File: doc/BRIEF.md
# Serial Flash Command Sequence Decoder

This block is the command front end of a serial flash slave. It watches the serial clock, chip select and serial data pins, assembles bytes, and recognises a small set of control commands. Some commands are one byte long. Others are four bytes long: either a shared three-byte prefix followed by a selector byte, or one fixed four-byte sequence. When a recognised command is complete, the block raises a one-cycle strobe in the system clock domain. The surrounding flash engine acts on that strobe. That engine does the array access, erase timing, payload storage and output driving, and none of it is part of this block.

The serial pins are treated as asynchronous. Each pin is passed through a multi-stage synchroniser and oversampled by the system clock. Bytes are shifted in most significant bit first on rising serial clock edges, so both idle clock polarities work (SPI modes 0 and 3). Four-byte and mode-changing commands are decided only when chip select rises, and only if the frame stopped exactly on a byte boundary. The status read opcode is different: it is acknowledged as soon as its byte is complete, because the host keeps clocking to read status data. The block also holds a power-down flag. While that flag is set, every opcode is locked out except the wake opcode. While the external busy input is high, only the status read opcode is honoured.

Top module: `sfd_cmd_decoder`

## Requirements
- R1: A falling chip select discards any partial byte and any partly matched sequence from the previous frame. A frame that was abandoned part way does not disturb the next frame.
- R2: Data is sampled on rising serial clock edges, most significant bit first. This works with the clock idling low (mode 0) or idling high (mode 3). A selector byte sent in reversed bit order is not recognised.
- R3: The sequence 3DH 2AH 7FH A9H pulses `prot_en_o`. The sequence 3DH 2AH 7FH 9AH pulses `prot_dis_o`.
- R4: The sequence 3DH 2AH 7FH CFH pulses `prot_erase_o`. The sequence 3DH 2AH 7FH FCH pulses `prot_prog_o`.
- R5: The sequence C7H 94H 80H 9AH pulses `chip_erase_o`.
- R6: A sequence-type command fires only if chip select rises when the bit count is a multiple of eight and exactly the required bytes were sent. Extra bits, an extra byte, or a missing byte produce no strobe.
- R7: A byte that breaks a multi-byte prefix makes the rest of the frame ignored. A correct sequence sent later in the same frame produces no strobe.
- R8: The single byte B9H pulses `pd_enter_o` and sets `pd_state_o` in the same cycle.
- R9: While `pd_state_o` is high, every opcode is ignored except ABH. ABH pulses `pd_exit_o` and clears `pd_state_o` in the same cycle. ABH sent while not powered down produces nothing.
- R10: While `busy_i` is high in the cycle a command would be accepted, only the status read opcode D7H produces a strobe.
- R11: A first byte of D7H pulses `status_rd_o` once, right after that byte completes, without waiting for chip select release. The bytes that follow in the same frame are ignored. A frame that ends after fewer than eight bits of D7H produces nothing.
- R12: Reset clears all strobes and `pd_state_o`. Every strobe lasts exactly one system clock cycle, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock pin (asynchronous) |
| cs_n_i | input | 1 | Chip select pin, active low (asynchronous) |
| si_i | input | 1 | Serial data in pin (asynchronous) |
| busy_i | input | 1 | High while a timed program or erase is running |
| prot_en_o | output | 1 | Protection enable strobe |
| prot_dis_o | output | 1 | Protection disable strobe |
| prot_erase_o | output | 1 | Protection register erase strobe |
| prot_prog_o | output | 1 | Protection register program strobe |
| chip_erase_o | output | 1 | Chip erase strobe |
| pd_enter_o | output | 1 | Power-down entry strobe |
| pd_exit_o | output | 1 | Power-down wake strobe |
| status_rd_o | output | 1 | Status read acknowledge strobe |
| pd_state_o | output | 1 | Power-down lockout flag |

## Verification
A wrong sequence state shows up as a missing strobe, an unexpected strobe, or a strobe of the wrong kind. It is visible a few system clocks after the chip select rises, or, for status read, right after the eighth bit. A stale bit counter or a stale match state carried across frames breaks the valid frame that follows an aborted one. A corrupt power-down flag shows directly on `pd_state_o`, and it also shows as commands that are wrongly accepted or wrongly dropped in the next frame. The scoreboard compares every strobe against a queue of expected events. After each frame it also checks that nothing is left unconsumed.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  localparam int OP_W = 8;

  // opcode values recognised by the matcher
  localparam logic [OP_W-1:0] OP_PFX0     = 8'h3D;
  localparam logic [OP_W-1:0] OP_PFX1     = 8'h2A;
  localparam logic [OP_W-1:0] OP_PFX2     = 8'h7F;
  localparam logic [OP_W-1:0] OP_SEL_EN   = 8'hA9;
  localparam logic [OP_W-1:0] OP_SEL_DIS  = 8'h9A;
  localparam logic [OP_W-1:0] OP_SEL_ERS  = 8'hCF;
  localparam logic [OP_W-1:0] OP_SEL_PRG  = 8'hFC;
  localparam logic [OP_W-1:0] OP_CE0      = 8'hC7;
  localparam logic [OP_W-1:0] OP_CE1      = 8'h94;
  localparam logic [OP_W-1:0] OP_CE2      = 8'h80;
  localparam logic [OP_W-1:0] OP_CE3      = 8'h9A;
  localparam logic [OP_W-1:0] OP_SLEEP    = 8'hB9;
  localparam logic [OP_W-1:0] OP_WAKE     = 8'hAB;
  localparam logic [OP_W-1:0] OP_STATUS   = 8'hD7;

  // strobe vector bit positions
  localparam int STB_PROT_EN    = 0;
  localparam int STB_PROT_DIS   = 1;
  localparam int STB_PROT_ERASE = 2;
  localparam int STB_PROT_PROG  = 3;
  localparam int STB_CHIP_ERASE = 4;
  localparam int STB_PD_ENTER   = 5;
  localparam int STB_PD_EXIT    = 6;
  localparam int STB_STATUS     = 7;
  localparam int NUM_STB        = 8;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_PROT_EN,
    CMD_PROT_DIS,
    CMD_PROT_ERASE,
    CMD_PROT_PROG,
    CMD_CHIP_ERASE,
    CMD_PD_ENTER,
    CMD_PD_EXIT
  } cmd_e;

  typedef enum logic [3:0] {
    SQ_FIRST,
    SQ_A1,
    SQ_A2,
    SQ_A3,
    SQ_B1,
    SQ_B2,
    SQ_B3,
    SQ_DONE,
    SQ_IGNORE
  } seq_e;

endpackage

// File: rtl/sfd_pin_sync.sv
module sfd_pin_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sfd_byte_shifter.sv
module sfd_byte_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              bit_en,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_done_o,
  output logic              aligned_o
);

  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (frame_start) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (bit_en) begin
      sh_q   <= {sh_q[BYTE_W-2:0], bit_i};
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      done_q <= (cnt_q == LAST);
    end else begin
      done_q <= 1'b0;
    end
  end

  assign byte_o      = sh_q;
  assign byte_done_o = done_q;
  assign aligned_o   = (cnt_q == '0);

endmodule

// File: rtl/sfd_seq_match.sv
module sfd_seq_match
  import sfd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_start,
  input  logic            byte_done,
  input  logic [OP_W-1:0] byte_i,
  input  logic            pd_state,
  output cmd_e            cmd_o,
  output logic            status_hit_o
);

  seq_e st_q, st_d;
  cmd_e cmd_q, cmd_d;
  logic hit_d, hit_q;

  always_comb begin
    st_d  = st_q;
    cmd_d = cmd_q;
    hit_d = 1'b0;
    if (frame_start) begin
      st_d  = SQ_FIRST;
      cmd_d = CMD_NONE;
    end else if (byte_done) begin
      st_d  = SQ_IGNORE;
      cmd_d = CMD_NONE;
      unique case (st_q)
        SQ_FIRST: begin
          if (pd_state) begin
            if (byte_i == OP_WAKE) begin
              st_d  = SQ_DONE;
              cmd_d = CMD_PD_EXIT;
            end
          end else begin
            case (byte_i)
              OP_PFX0:   st_d = SQ_A1;
              OP_CE0:    st_d = SQ_B1;
              OP_SLEEP: begin
                st_d  = SQ_DONE;
                cmd_d = CMD_PD_ENTER;
              end
              OP_STATUS: hit_d = 1'b1;
              default:   st_d = SQ_IGNORE;
            endcase
          end
        end
        SQ_A1: if (byte_i == OP_PFX1) st_d = SQ_A2;
        SQ_A2: if (byte_i == OP_PFX2) st_d = SQ_A3;
        SQ_A3: begin
          case (byte_i)
            OP_SEL_EN:  begin st_d = SQ_DONE; cmd_d = CMD_PROT_EN;    end
            OP_SEL_DIS: begin st_d = SQ_DONE; cmd_d = CMD_PROT_DIS;   end
            OP_SEL_ERS: begin st_d = SQ_DONE; cmd_d = CMD_PROT_ERASE; end
            OP_SEL_PRG: begin st_d = SQ_DONE; cmd_d = CMD_PROT_PROG;  end
            default:    st_d = SQ_IGNORE;
          endcase
        end
        SQ_B1: if (byte_i == OP_CE1) st_d = SQ_B2;
        SQ_B2: if (byte_i == OP_CE2) st_d = SQ_B3;
        SQ_B3: begin
          if (byte_i == OP_CE3) begin
            st_d  = SQ_DONE;
            cmd_d = CMD_CHIP_ERASE;
          end
        end
        default: st_d = SQ_IGNORE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_FIRST;
      cmd_q <= CMD_NONE;
      hit_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      hit_q <= hit_d;
    end
  end

  assign cmd_o        = (st_q == SQ_DONE) ? cmd_q : CMD_NONE;
  assign status_hit_o = hit_q;

endmodule

// File: rtl/sfd_cmd_decoder.sv
module sfd_cmd_decoder
  import sfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  input  logic busy_i,
  output logic prot_en_o,
  output logic prot_dis_o,
  output logic prot_erase_o,
  output logic prot_prog_o,
  output logic chip_erase_o,
  output logic pd_enter_o,
  output logic pd_exit_o,
  output logic status_rd_o,
  output logic pd_state_o
);

  // pin order in the synchroniser: {cs_n, sck, si}
  localparam logic [2:0] PIN_RST = 3'b100;

  logic [2:0] pins_s;
  logic       sck_s, cs_n_s, si_s;
  logic       sck_prev_q, cs_n_prev_q;
  logic       sck_rise, cs_fall, cs_rise, bit_en;

  logic [OP_W-1:0] byte_w;
  logic            byte_done, aligned;
  cmd_e            pend_cmd;
  logic            status_hit;

  logic [NUM_STB-1:0] stb_d, stb_q;
  logic               pd_d, pd_q;
  logic               fire;

  sfd_pin_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({cs_n_i, sck_i, si_i}),
    .dout (pins_s)
  );

  assign cs_n_s = pins_s[2];
  assign sck_s  = pins_s[1];
  assign si_s   = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev_q  <= 1'b0;
      cs_n_prev_q <= 1'b1;
    end else begin
      sck_prev_q  <= sck_s;
      cs_n_prev_q <= cs_n_s;
    end
  end

  assign sck_rise = sck_s & ~sck_prev_q;
  assign cs_fall  = ~cs_n_s & cs_n_prev_q;
  assign cs_rise  = cs_n_s & ~cs_n_prev_q;
  assign bit_en   = sck_rise & ~cs_n_s;

  sfd_byte_shifter #(
    .BYTE_W (OP_W)
  ) u_shift (
    .clk         (clk),
    .rst         (rst),
    .frame_start (cs_fall),
    .bit_en      (bit_en),
    .bit_i       (si_s),
    .byte_o      (byte_w),
    .byte_done_o (byte_done),
    .aligned_o   (aligned)
  );

  sfd_seq_match u_match (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (cs_fall),
    .byte_done    (byte_done),
    .byte_i       (byte_w),
    .pd_state     (pd_q),
    .cmd_o        (pend_cmd),
    .status_hit_o (status_hit)
  );

  assign fire = cs_rise & aligned & ~busy_i & (pend_cmd != CMD_NONE);

  always_comb begin
    stb_d = '0;
    pd_d  = pd_q;
    if (fire) begin
      unique case (pend_cmd)
        CMD_PROT_EN:    stb_d[STB_PROT_EN]    = 1'b1;
        CMD_PROT_DIS:   stb_d[STB_PROT_DIS]   = 1'b1;
        CMD_PROT_ERASE: stb_d[STB_PROT_ERASE] = 1'b1;
        CMD_PROT_PROG:  stb_d[STB_PROT_PROG]  = 1'b1;
        CMD_CHIP_ERASE: stb_d[STB_CHIP_ERASE] = 1'b1;
        CMD_PD_ENTER: begin
          stb_d[STB_PD_ENTER] = 1'b1;
          pd_d                = 1'b1;
        end
        CMD_PD_EXIT: begin
          stb_d[STB_PD_EXIT] = 1'b1;
          pd_d               = 1'b0;
        end
        default: ;
      endcase
    end
    if (status_hit) stb_d[STB_STATUS] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= '0;
      pd_q  <= 1'b0;
    end else begin
      stb_q <= stb_d;
      pd_q  <= pd_d;
    end
  end

  assign prot_en_o    = stb_q[STB_PROT_EN];
  assign prot_dis_o   = stb_q[STB_PROT_DIS];
  assign prot_erase_o = stb_q[STB_PROT_ERASE];
  assign prot_prog_o  = stb_q[STB_PROT_PROG];
  assign chip_erase_o = stb_q[STB_CHIP_ERASE];
  assign pd_enter_o   = stb_q[STB_PD_ENTER];
  assign pd_exit_o    = stb_q[STB_PD_EXIT];
  assign status_rd_o  = stb_q[STB_STATUS];
  assign pd_state_o   = pd_q;

endmodule

// File: rtl/sfd_cmd_decoder_chk.sv
module sfd_cmd_decoder_chk (
  input logic clk,
  input logic rst,
  input logic busy_i,
  input logic prot_en_o,
  input logic prot_dis_o,
  input logic prot_erase_o,
  input logic prot_prog_o,
  input logic chip_erase_o,
  input logic pd_enter_o,
  input logic pd_exit_o,
  input logic status_rd_o,
  input logic pd_state_o
);

  logic [7:0] stb;
  assign stb = {status_rd_o, pd_exit_o, pd_enter_o, chip_erase_o,
                prot_prog_o, prot_erase_o, prot_dis_o, prot_en_o};

  // R12: never two strobes at once
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));

  // R12: a strobe is followed by a quiet cycle
  a_r12_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (stb != 8'h00) |=> (stb == 8'h00));

  // R8: entry strobe comes with the flag set
  a_r8_enter_sets: assert property (@(posedge clk) disable iff (rst)
    pd_enter_o |-> pd_state_o);

  // R9: wake strobe comes with the flag cleared
  a_r9_exit_clears: assert property (@(posedge clk) disable iff (rst)
    pd_exit_o |-> !pd_state_o);

  // R8 / R9: the flag moves only together with its strobes
  a_r9_flag_moves: assert property (@(posedge clk) disable iff (rst)
    !$stable(pd_state_o) |-> (pd_enter_o || pd_exit_o));

  // R9: while powered down only the wake strobe may appear
  a_r9_lockout: assert property (@(posedge clk) disable iff (rst)
    $past(pd_state_o) |-> ((stb & 8'hBF) == 8'h00));

  // R10: busy lets only the status strobe through
  a_r10_busy_gate: assert property (@(posedge clk) disable iff (rst)
    $past(busy_i) |-> ((stb & 8'h7F) == 8'h00));

endmodule

bind sfd_cmd_decoder sfd_cmd_decoder_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy_i       (busy_i),
  .prot_en_o    (prot_en_o),
  .prot_dis_o   (prot_dis_o),
  .prot_erase_o (prot_erase_o),
  .prot_prog_o  (prot_prog_o),
  .chip_erase_o (chip_erase_o),
  .pd_enter_o   (pd_enter_o),
  .pd_exit_o    (pd_exit_o),
  .status_rd_o  (status_rd_o),
  .pd_state_o   (pd_state_o)
);

// File: tb/sfd_cmd_decoder_bench.sv
module sfd_cmd_decoder_bench;

  localparam int HALF = 4;   // system clocks per serial half period

  localparam logic [7:0] E_EN   = 8'h01;
  localparam logic [7:0] E_DIS  = 8'h02;
  localparam logic [7:0] E_ERS  = 8'h04;
  localparam logic [7:0] E_PRG  = 8'h08;
  localparam logic [7:0] E_CE   = 8'h10;
  localparam logic [7:0] E_PDE  = 8'h20;
  localparam logic [7:0] E_PDX  = 8'h40;
  localparam logic [7:0] E_STAT = 8'h80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic busy = 1'b0;

  logic prot_en_o, prot_dis_o, prot_erase_o, prot_prog_o;
  logic chip_erase_o, pd_enter_o, pd_exit_o, status_rd_o, pd_state_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit mode3 = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  sfd_cmd_decoder u_sfd_cmd_decoder (
    .clk          (clk),
    .rst          (rst),
    .sck_i        (sck),
    .cs_n_i       (cs_n),
    .si_i         (si),
    .busy_i       (busy),
    .prot_en_o    (prot_en_o),
    .prot_dis_o   (prot_dis_o),
    .prot_erase_o (prot_erase_o),
    .prot_prog_o  (prot_prog_o),
    .chip_erase_o (chip_erase_o),
    .pd_enter_o   (pd_enter_o),
    .pd_exit_o    (pd_exit_o),
    .status_rd_o  (status_rd_o),
    .pd_state_o   (pd_state_o)
  );

  logic [7:0] obs;
  assign obs = {status_rd_o, pd_exit_o, pd_enter_o, chip_erase_o,
                prot_prog_o, prot_erase_o, prot_dis_o, prot_en_o};

  // monitor: every strobe must match the head of the queue
  always @(negedge clk) begin
    if (!rst && obs != 8'h00) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected strobe: actual %02h expected 00", obs);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (obs != e) begin
          errors++;
          $display("FAIL %s strobe: actual %02h expected %02h", t, obs, e);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_stb(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic frame_begin();
    sck = mode3;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic tx_bit(input logic b);
    sck = 1'b0;
    si  = b;
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic tx_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) tx_bit(b[i]);
  endtask

  task automatic frame_end();
    if (!mode3) sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic check_drained(input string t);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing strobe: actual none expected %02h", t, exp_q[0]);
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic check_pd(input logic e, input string t);
    checks++;
    if (pd_state_o !== e) begin
      errors++;
      $display("FAIL %s pd_state: actual %0b expected %0b", t, pd_state_o, e);
    end
  endtask

  task automatic send4(input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3);
    frame_begin();
    tx_byte(b0); tx_byte(b1); tx_byte(b2); tx_byte(b3);
    frame_end();
  endtask

  task automatic send1(input logic [7:0] b0);
    frame_begin();
    tx_byte(b0);
    frame_end();
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R12: reset state
    checks++;
    if (obs !== 8'h00 || pd_state_o !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: actual %02h/%0b expected 00/0", obs, pd_state_o);
    end

    // R3 mode 0
    expect_stb(E_EN, "R3 enable");
    send4(8'h3D, 8'h2A, 8'h7F, 8'hA9);
    check_drained("R3 enable");
    // R2 / R3 in mode 3
    mode3 = 1;
    expect_stb(E_DIS, "R2 R3 disable mode3");
    send4(8'h3D, 8'h2A, 8'h7F, 8'h9A);
    check_drained("R2 mode3");
    mode3 = 0;
    // R4
    expect_stb(E_ERS, "R4 erase");
    send4(8'h3D, 8'h2A, 8'h7F, 8'hCF);
    check_drained("R4 erase");
    expect_stb(E_PRG, "R4 program");
    send4(8'h3D, 8'h2A, 8'h7F, 8'hFC);
    check_drained("R4 program");
    // R5
    expect_stb(E_CE, "R5 chip erase");
    send4(8'hC7, 8'h94, 8'h80, 8'h9A);
    check_drained("R5 chip erase");

    // R6: extra bits
    frame_begin();
    tx_byte(8'hC7); tx_byte(8'h94); tx_byte(8'h80); tx_byte(8'h9A);
    tx_bit(1'b0); tx_bit(1'b1); tx_bit(1'b0);
    frame_end();
    check_drained("R6 extra bits");
    // R6: extra byte
    frame_begin();
    tx_byte(8'h3D); tx_byte(8'h2A); tx_byte(8'h7F); tx_byte(8'hA9); tx_byte(8'h00);
    frame_end();
    check_drained("R6 extra byte");
    // R6: missing byte
    frame_begin();
    tx_byte(8'h3D); tx_byte(8'h2A); tx_byte(8'h7F);
    frame_end();
    check_drained("R6 short");

    // R7: broken prefix, then good sequence in same frame
    frame_begin();
    tx_byte(8'h3D); tx_byte(8'h2A); tx_byte(8'h00);
    tx_byte(8'h3D); tx_byte(8'h2A); tx_byte(8'h7F); tx_byte(8'hA9);
    frame_end();
    check_drained("R7 ignore");

    // R1: aborted frame then valid frame
    frame_begin();
    tx_byte(8'h3D); tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    frame_end();
    expect_stb(E_EN, "R1 after abort");
    send4(8'h3D, 8'h2A, 8'h7F, 8'hA9);
    check_drained("R1 after abort");

    // R2: reversed selector (A9 bit-reversed = 95)
    send4(8'h3D, 8'h2A, 8'h7F, 8'h95);
    check_drained("R2 reversed");

    // R11: status with trailing bytes
    expect_stb(E_STAT, "R11 status");
    frame_begin();
    tx_byte(8'hD7); tx_byte(8'h3D); tx_byte(8'h2A);
    frame_end();
    check_drained("R11 status");
    // R11: only seven bits
    frame_begin();
    for (int i = 7; i >= 1; i--) tx_bit(1'(8'hD7 >> i));
    frame_end();
    check_drained("R11 short status");

    // R10: busy
    busy = 1'b1;
    send4(8'h3D, 8'h2A, 8'h7F, 8'hA9);
    check_drained("R10 busy blocks");
    send1(8'hB9);
    check_drained("R10 busy sleep");
    check_pd(1'b0, "R10 busy sleep");
    expect_stb(E_STAT, "R10 busy status");
    send1(8'hD7);
    check_drained("R10 busy status");
    busy = 1'b0;

    // R9: wake outside power-down
    send1(8'hAB);
    check_drained("R9 wake idle");
    check_pd(1'b0, "R9 wake idle");

    // R8: enter power-down (mode 3)
    mode3 = 1;
    expect_stb(E_PDE, "R8 enter");
    send1(8'hB9);
    check_drained("R8 enter");
    check_pd(1'b1, "R8 enter");
    mode3 = 0;

    // R9: lockout
    send4(8'h3D, 8'h2A, 8'h7F, 8'hA9);
    check_drained("R9 lock prot");
    send4(8'hC7, 8'h94, 8'h80, 8'h9A);
    check_drained("R9 lock erase");
    send1(8'hD7);
    check_drained("R9 lock status");
    send1(8'hB9);
    check_drained("R9 lock sleep");
    check_pd(1'b1, "R9 still down");

    // R9: wake
    expect_stb(E_PDX, "R9 wake");
    send1(8'hAB);
    check_drained("R9 wake");
    check_pd(1'b0, "R9 wake");
    expect_stb(E_EN, "R9 after wake");
    send4(8'h3D, 8'h2A, 8'h7F, 8'hA9);
    check_drained("R9 after wake");

    // R12: reset clears power-down
    expect_stb(E_PDE, "R12 enter");
    send1(8'hB9);
    check_drained("R12 enter");
    @(negedge clk) rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    wait_clk(2);
    check_pd(1'b0, "R12 reset clears");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule